// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register file of a sixteen-pin general-purpose I/O port. A host reaches it through a 32-bit word bus that has a byte address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data comes back on the cycle after the read strobe. Each pin has its own settings: a function mode, an output driver type, a speed grade, a pull choice, an alternate-function index and a security flag. The bank also holds an output data word and samples the pad inputs into an input data word.

Software changes single output bits without a read-modify-write cycle by writing the set/clear register. The lower half of that write drives pins high and the upper half drives them low. The bank registers every pad-side selection before export: output value, output enable, open-drain flag, pull-up and pull-down requests, and the alternate-function index. Pad circuitry, clock gating and the peripheral multiplexer are outside the block.

Each bus access carries a non-secure sideband bit. When a pin's security flag is 1, non-secure traffic cannot change that pin's fields and reads them back as zero.

Top module: `gpio_port_regs`

## Requirements
- R1: The mode register (offset 0x00) holds 2 bits per pin at bit 2n. The codes are 00 input, 01 output, 10 alternate function and 11 analog. Every bit reads back as written.
- R2: Three registers hold 1 bit per pin at bit n: output type (0x04), output data (0x14) and security (0x30). Output type 1 sets `pad_od` for the pin. The output data bit drives `pad_out`. Bits 31:16 read as zero.
- R3: Speed (0x08) and pull (0x0C) hold 2 bits per pin at bit 2n. Pull code 01 requests pull-up, 10 requests pull-down, and 00 or 11 requests no pull. The requests appear on `pad_pu` and `pad_pd`.
- R4: The alternate-function index is 4 bits per pin. Pins 0-7 sit in register 0x20 at bit 4n, and pins 8-15 sit in register 0x24 at bit 4(n-8). Pin n's index appears on `pad_af[4n+3:4n]`.
- R5: A write to 0x18 with bit n set drives output bit n high. Bit n+16 set drives output bit n low. If both are set, the pin goes high. If neither is set, the pin keeps its value. Register 0x18 always reads as zero.
- R6: `pad_oe` is 1 for a pin only in output or alternate-function mode. In analog mode, `pad_pu` and `pad_pd` are 0 whatever the pull field holds.
- R7: The input data register (0x10) returns the pad inputs through a two-stage synchronizer. A pad change becomes visible to a read strobe issued on the third clock edge after the change. Bits 31:16 read as zero.
- R8: Non-secure writes leave unchanged every field of a pin whose security bit is 1. Non-secure reads return zero in those fields, including input data. Only secure writes may change the security register. The security register reads back in full at either privilege.
- R9: After reset, every mode field is analog (0x00 reads 0xFFFFFFFF). Output type, speed, pull, output data, both alternate-function registers and security are zero. All pad outputs are zero.
- R10: Read data appears on the cycle after the read strobe. An unmapped offset reads as zero, and a write to it has no effect. Pad outputs follow a register write one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | One-cycle write strobe |
| bus_re | input | 1 | One-cycle read strobe |
| bus_nonsec | input | 1 | Access is non-secure |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Output driver enable per pin |
| pad_od | output | 16 | Open-drain select per pin |
| pad_pu | output | 16 | Pull-up request per pin |
| pad_pd | output | 16 | Pull-down request per pin |
| pad_af | output | 64 | Alternate-function index, 4 bits per pin |

## Verification
Five rules are checked by assertions on every cycle:
- output enable follows the previous cycle's mode;
- pulls drop in analog mode;
- set bits of a secure set/clear write land high, and clear-only bits land low;
- the set/clear register and the upper half of the input word read zero;
- non-secure writes cannot change the security word.

The remaining behaviour is shown only by bench scenarios:
- field placement for every pin;
- alternate-function splitting across two registers;
- synchronizer latency;
- masking of non-secure reads and writes on a mixed secure/non-secure port;
- reset values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_AW = 8;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam logic [1:0] PULL_UP   = 2'b01;
  localparam logic [1:0] PULL_DOWN = 2'b10;

  localparam logic [REG_AW-1:0] OFS_MODE   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_OTYPE  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_SPEED  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_PULL   = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_IDATA  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_ODATA  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_SETCLR = 8'h18;
  localparam logic [REG_AW-1:0] OFS_AFLO   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_AFHI   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_SEC    = 8'h30;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_OTYPE, SEL_SPEED, SEL_PULL, SEL_IDATA,
    SEL_ODATA, SEL_SETCLR, SEL_AFLO, SEL_AFHI, SEL_SEC
  } reg_sel_e;

  function automatic reg_sel_e reg_decode(input logic [REG_AW-1:0] a);
    case (a)
      OFS_MODE:   return SEL_MODE;
      OFS_OTYPE:  return SEL_OTYPE;
      OFS_SPEED:  return SEL_SPEED;
      OFS_PULL:   return SEL_PULL;
      OFS_IDATA:  return SEL_IDATA;
      OFS_ODATA:  return SEL_ODATA;
      OFS_SETCLR: return SEL_SETCLR;
      OFS_AFLO:   return SEL_AFLO;
      OFS_AFHI:   return SEL_AFHI;
      OFS_SEC:    return SEL_SEC;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
// Per-pin configuration storage with security-gated writes.
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int AF_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_nonsec,
  input  reg_sel_e               wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [2*NPIN-1:0]      mode_q,
  output logic [NPIN-1:0]        otype_q,
  output logic [2*NPIN-1:0]      speed_q,
  output logic [2*NPIN-1:0]      pull_q,
  output logic [NPIN*AF_W-1:0]   af_q,
  output logic [NPIN-1:0]        odr_q,
  output logic [NPIN-1:0]        sec_q
);

  localparam int HALF = DATA_W / 2;
  localparam int AFPR = DATA_W / AF_W;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int AFR = p / AFPR;
    localparam int AFO = AF_W * (p % AFPR);

    logic [1:0]      md_r, sp_r, pl_r;
    logic            ot_r, od_r, sc_r;
    logic [AF_W-1:0] af_r;
    logic            wen;

    // a secure pin rejects non-secure traffic
    assign wen = wr_en & ~(wr_nonsec & sc_r);

    always_ff @(posedge clk) begin
      if (rst) begin
        md_r <= PM_ANA;
        sp_r <= '0;
        pl_r <= '0;
        ot_r <= 1'b0;
        od_r <= 1'b0;
        sc_r <= 1'b0;
        af_r <= '0;
      end else if (wen) begin
        case (wr_sel)
          SEL_MODE:  md_r <= wr_data[2*p +: 2];
          SEL_OTYPE: ot_r <= wr_data[p];
          SEL_SPEED: sp_r <= wr_data[2*p +: 2];
          SEL_PULL:  pl_r <= wr_data[2*p +: 2];
          SEL_ODATA: od_r <= wr_data[p];
          SEL_SETCLR: begin
            if (wr_data[p])             od_r <= 1'b1;
            else if (wr_data[HALF + p]) od_r <= 1'b0;
          end
          SEL_AFLO: if (AFR == 0) af_r <= wr_data[AFO +: AF_W];
          SEL_AFHI: if (AFR == 1) af_r <= wr_data[AFO +: AF_W];
          SEL_SEC:  if (!wr_nonsec) sc_r <= wr_data[p];
          default: ;
        endcase
      end
    end

    assign mode_q[2*p +: 2]      = md_r;
    assign speed_q[2*p +: 2]     = sp_r;
    assign pull_q[2*p +: 2]      = pl_r;
    assign otype_q[p]            = ot_r;
    assign odr_q[p]              = od_r;
    assign sec_q[p]              = sc_r;
    assign af_q[AF_W*p +: AF_W]  = af_r;
  end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
module gpio_in_sync #(
  parameter int NPIN        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] idata_q
);

  logic [NPIN-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= pad_in;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign idata_q = stg[SYNC_STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
// Registered pad-side selections derived from the configuration.
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int AF_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NPIN-1:0]    mode_q,
  input  logic [NPIN-1:0]      otype_q,
  input  logic [2*NPIN-1:0]    pull_q,
  input  logic [NPIN*AF_W-1:0] af_q,
  input  logic [NPIN-1:0]      odr_q,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_od,
  output logic [NPIN-1:0]      pad_pu,
  output logic [NPIN-1:0]      pad_pd,
  output logic [NPIN*AF_W-1:0] pad_af
);

  logic [NPIN-1:0] oe_d, pu_d, pd_d;

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      oe_d[p] = (mode_q[2*p +: 2] == PM_OUT) || (mode_q[2*p +: 2] == PM_ALT);
      pu_d[p] = (mode_q[2*p +: 2] != PM_ANA) && (pull_q[2*p +: 2] == PULL_UP);
      pd_d[p] = (mode_q[2*p +: 2] != PM_ANA) && (pull_q[2*p +: 2] == PULL_DOWN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_od  <= '0;
      pad_pu  <= '0;
      pad_pd  <= '0;
      pad_af  <= '0;
    end else begin
      pad_out <= odr_q;
      pad_oe  <= oe_d;
      pad_od  <= otype_q;
      pad_pu  <= pu_d;
      pad_pd  <= pd_d;
      pad_af  <= af_q;
    end
  end

endmodule

// File: rtl/gpio_read_mux.sv
// Registered read port with per-pin masking for non-secure reads.
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int AF_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 rd_nonsec,
  input  reg_sel_e             rd_sel,
  input  logic [2*NPIN-1:0]    mode_q,
  input  logic [NPIN-1:0]      otype_q,
  input  logic [2*NPIN-1:0]    speed_q,
  input  logic [2*NPIN-1:0]    pull_q,
  input  logic [NPIN*AF_W-1:0] af_q,
  input  logic [NPIN-1:0]      odr_q,
  input  logic [NPIN-1:0]      sec_q,
  input  logic [NPIN-1:0]      idata_q,
  output logic [DATA_W-1:0]    rdata
);

  localparam int AFPR = DATA_W / AF_W;

  logic [NPIN-1:0]   vis;
  logic [DATA_W-1:0] w_mode, w_speed, w_pull, w_aflo, w_afhi;
  logic [DATA_W-1:0] w_otype, w_odr, w_idata;

  assign vis = rd_nonsec ? ~sec_q : '1;

  always_comb begin
    w_mode  = '0;
    w_speed = '0;
    w_pull  = '0;
    w_aflo  = '0;
    w_afhi  = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (vis[p]) begin
        w_mode[2*p +: 2]  = mode_q[2*p +: 2];
        w_speed[2*p +: 2] = speed_q[2*p +: 2];
        w_pull[2*p +: 2]  = pull_q[2*p +: 2];
        if (p < AFPR) w_aflo[AF_W*(p % AFPR) +: AF_W] = af_q[AF_W*p +: AF_W];
        else          w_afhi[AF_W*(p % AFPR) +: AF_W] = af_q[AF_W*p +: AF_W];
      end
    end
    w_otype = DATA_W'(otype_q & vis);
    w_odr   = DATA_W'(odr_q & vis);
    w_idata = DATA_W'(idata_q & vis);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (rd_sel)
        SEL_MODE:  rdata <= w_mode;
        SEL_OTYPE: rdata <= w_otype;
        SEL_SPEED: rdata <= w_speed;
        SEL_PULL:  rdata <= w_pull;
        SEL_IDATA: rdata <= w_idata;
        SEL_ODATA: rdata <= w_odr;
        SEL_AFLO:  rdata <= w_aflo;
        SEL_AFHI:  rdata <= w_afhi;
        SEL_SEC:   rdata <= DATA_W'(sec_q);
        default:   rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
// Sixteen-pin GPIO port register bank: top level.
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPIN        = 16,
  parameter int AF_W        = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic                 bus_nonsec,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NPIN-1:0]      pad_in,
  output logic [NPIN-1:0]      pad_out,
  output logic [NPIN-1:0]      pad_oe,
  output logic [NPIN-1:0]      pad_od,
  output logic [NPIN-1:0]      pad_pu,
  output logic [NPIN-1:0]      pad_pd,
  output logic [NPIN*AF_W-1:0] pad_af
);

  reg_sel_e              sel;
  logic [2*NPIN-1:0]     mode_q, speed_q, pull_q;
  logic [NPIN-1:0]       otype_q, odr_q, sec_q, idata_q;
  logic [NPIN*AF_W-1:0]  af_q;

  assign sel = reg_decode(bus_addr);

  gpio_cfg_bank #(.NPIN(NPIN), .AF_W(AF_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_nonsec(bus_nonsec),
    .wr_sel(sel), .wr_data(bus_wdata),
    .mode_q(mode_q), .otype_q(otype_q), .speed_q(speed_q), .pull_q(pull_q),
    .af_q(af_q), .odr_q(odr_q), .sec_q(sec_q)
  );

  gpio_in_sync #(.NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .idata_q(idata_q)
  );

  gpio_pad_drive #(.NPIN(NPIN), .AF_W(AF_W)) u_pad (
    .clk(clk), .rst(rst), .mode_q(mode_q), .otype_q(otype_q),
    .pull_q(pull_q), .af_q(af_q), .odr_q(odr_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_af(pad_af)
  );

  gpio_read_mux #(.NPIN(NPIN), .AF_W(AF_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_re), .rd_nonsec(bus_nonsec),
    .rd_sel(sel), .mode_q(mode_q), .otype_q(otype_q), .speed_q(speed_q),
    .pull_q(pull_q), .af_q(af_q), .odr_q(odr_q), .sec_q(sec_q),
    .idata_q(idata_q), .rdata(bus_rdata)
  );

endmodule

// File: rtl/gpio_port_chk.sv
// Property checker bound to the GPIO port register bank.
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPIN   = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_nonsec,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [2*NPIN-1:0] mode_q,
  input logic [NPIN-1:0]   odr_q,
  input logic [NPIN-1:0]   sec_q,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_pu,
  input logic [NPIN-1:0]   pad_pd
);

  localparam int HALF = DATA_W / 2;

  logic [NPIN-1:0] drv_mode, ana_mode;

  always_comb begin
    for (int p = 0; p < NPIN; p++) begin
      drv_mode[p] = (mode_q[2*p +: 2] == 2'b01) || (mode_q[2*p +: 2] == 2'b10);
      ana_mode[p] = (mode_q[2*p +: 2] == 2'b11);
    end
  end

  a_r6_oe_mode: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pad_oe == $past(drv_mode));

  a_r6_no_pull_analog: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_pu | pad_pd) & $past(ana_mode)) == '0);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_nonsec && bus_addr == OFS_SETCLR)
    |=> (odr_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0]));

  a_r5_clear_low: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_nonsec && bus_addr == OFS_SETCLR)
    |=> (odr_q & $past(bus_wdata[HALF+NPIN-1:HALF]) & ~$past(bus_wdata[NPIN-1:0])) == '0);

  a_r5_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == OFS_SETCLR) |=> bus_rdata == '0);

  a_r7_idata_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == OFS_IDATA) |=> bus_rdata[DATA_W-1:NPIN] == '0);

  a_r8_sec_guard: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_nonsec) |=> $stable(sec_q));

endmodule

bind gpio_port_regs gpio_port_chk #(.NPIN(NPIN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_nonsec(bus_nonsec),
  .bus_rdata(bus_rdata), .mode_q(mode_q), .odr_q(odr_q), .sec_q(sec_q),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_nonsec = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [63:0] pad_af;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_nonsec(bus_nonsec),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_af(pad_af)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic ns);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_nonsec = ns; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_nonsec = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic ns, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_nonsec = ns; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0; bus_nonsec = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    logic [31:0] d, pat, msk, exp_w;
    logic [7:0]  a;
    logic [15:0] model, st, cl, e_oe, e_pu, e_pd;
    logic [63:0] e_af;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(8'h00, 0, d); check("R9 mode reset", d, 32'hFFFFFFFF);
    rd(8'h04, 0, d); check("R9 otype reset", d, 0);
    rd(8'h0C, 0, d); check("R9 pull reset", d, 0);
    rd(8'h20, 0, d); check("R9 aflo reset", d, 0);
    rd(8'h30, 0, d); check("R9 sec reset", d, 0);
    check("R9 pads reset", {pad_oe, pad_pu, pad_pd, pad_out}, 0);
    check("R9 af reset", pad_af, 0);

    // readback sweep across registers and patterns
    for (int k = 0; k < 4; k++) begin
      pat = 32'h9E3779B9 * (k + 1);
      for (int r = 0; r < 7; r++) begin
        case (r)
          0: begin a = 8'h00; msk = 32'hFFFFFFFF; end
          1: begin a = 8'h04; msk = 32'h0000FFFF; end
          2: begin a = 8'h08; msk = 32'hFFFFFFFF; end
          3: begin a = 8'h0C; msk = 32'hFFFFFFFF; end
          4: begin a = 8'h14; msk = 32'h0000FFFF; end
          5: begin a = 8'h20; msk = 32'hFFFFFFFF; end
          default: begin a = 8'h24; msk = 32'hFFFFFFFF; end
        endcase
        wr(a, pat ^ (32'h01010101 * r), 0);
        rd(a, 0, d);
        check("R1 R2 R3 R10 readback", d, (pat ^ (32'h01010101 * r)) & msk);
      end
    end

    // unmapped offset
    wr(8'h00, 32'h12345678, 0);
    wr(8'h2C, 32'hFFFFFFFF, 0);
    rd(8'h2C, 0, d); check("R10 unmapped reads zero", d, 0);
    rd(8'h00, 0, d); check("R10 unmapped write no effect", d, 32'h12345678);

    // alternate-function index per pin
    e_af = '0;
    for (int n = 0; n < 16; n++) e_af[4*n +: 4] = 4'((n * 7 + 3) & 15);
    wr(8'h20, e_af[31:0], 0);
    wr(8'h24, e_af[63:32], 0);
    @(negedge clk);
    for (int n = 0; n < 16; n++)
      check("R4 pad_af field", 64'(pad_af[4*n +: 4]), 64'((n * 7 + 3) & 15));

    // output type and data to pads
    wr(8'h04, 32'h0000A5C3, 0);
    wr(8'h14, 32'h00003C5A, 0);
    @(negedge clk);
    check("R2 pad_od", pad_od, 16'hA5C3);
    check("R2 pad_out", pad_out, 16'h3C5A);

    // mode x pull sweep per pin
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 4; m++)
        for (int pl = 1; pl < 3; pl++) begin
          wr(8'h0C, (pl == 1) ? 32'h55555555 : 32'hAAAAAAAA, 0);
          wr(8'h00, (32'hFFFFFFFF & ~(32'h3 << (2*n))) | (32'(m) << (2*n)), 0);
          @(negedge clk);
          e_oe = (m == 1 || m == 2) ? (16'h1 << n) : 16'h0;
          e_pu = (m != 3 && pl == 1) ? (16'h1 << n) : 16'h0;
          e_pd = (m != 3 && pl == 2) ? (16'h1 << n) : 16'h0;
          check("R6 pad_oe per mode", pad_oe, e_oe);
          check("R3 R6 pad_pu", pad_pu, e_pu);
          check("R3 R6 pad_pd", pad_pd, e_pd);
        end

    // set/clear register
    wr(8'h14, 32'h00000F0F, 0);
    wr(8'h18, {16'h00FF, 16'h0F03}, 0);
    rd(8'h14, 0, d); check("R5 set wins over clear", d, 32'h00000F03);
    rd(8'h18, 0, d); check("R5 setclr reads zero", d, 0);
    wr(8'h18, 32'h0, 0);
    rd(8'h14, 0, d); check("R5 zero write keeps", d, 32'h00000F03);
    model = 16'h0F03;
    for (int k = 0; k < 16; k++) begin
      st = 16'((k * 16'h1357) & 16'hFFFF);
      cl = 16'((k * 16'h2468 + 16'h0F0F) & 16'hFFFF);
      wr(8'h18, {cl, st}, 0);
      model = (model & ~cl) | st;
      rd(8'h14, 0, d); check("R5 setclr sweep", d, 32'(model));
    end
    @(negedge clk);
    check("R2 R5 pad_out follows", pad_out, model);

    // input synchronizer latency
    @(negedge clk);
    pad_in = 16'hBEEF; bus_addr = 8'h10; bus_re = 1'b1;
    @(negedge clk); check("R7 idata after 1 edge", bus_rdata, 0);
    @(negedge clk); check("R7 idata after 2 edges", bus_rdata, 0);
    @(negedge clk); check("R7 idata after 3 edges", bus_rdata, 32'h0000BEEF);
    bus_re = 1'b0;

    // security masking
    do_reset();
    pad_in = 16'hFFFF;
    wr(8'h30, 32'h000000FF, 0);
    wr(8'h00, 32'h55555555, 1);
    rd(8'h00, 0, d); check("R8 nonsec write masked", d, 32'h5555FFFF);
    rd(8'h00, 1, d); check("R8 nonsec read masked", d, 32'h55550000);
    wr(8'h30, 32'h0, 1);
    rd(8'h30, 0, d); check("R8 sec reg guarded", d, 32'h000000FF);
    rd(8'h30, 1, d); check("R8 sec reg visible", d, 32'h000000FF);
    wr(8'h18, 32'h0000FFFF, 1);
    rd(8'h14, 0, d); check("R8 R5 nonsec setclr masked", d, 32'h0000FF00);
    wr(8'h20, 32'hFFFFFFFF, 1);
    rd(8'h20, 0, d); check("R8 aflo nonsec ignored", d, 0);
    wr(8'h24, 32'h87654321, 1);
    rd(8'h24, 1, d); check("R8 afhi open pins", d, 32'h87654321);
    rd(8'h10, 1, d); check("R8 idata nonsec masked", d, 32'h0000FF00);
    rd(8'h10, 0, d); check("R7 R8 idata secure", d, 32'h0000FFFF);
    wr(8'h30, 32'h0, 0);
    rd(8'h30, 0, d); check("R8 secure clears sec", d, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule